// File: doc/BRIEF.md
# ADC Sample Buffer with Conversion Down-Counter

This block sits behind an analog-to-digital converter. It collects each finished conversion into a first-in first-out store of 1024 words, and software drains that store through a 16-bit read port. Each stored word holds the 12-bit result in bits 15:4 and a 4-bit tag (channel number or don't-care) in bits 3:0. The converter is modelled as a result word plus a one-cycle done strobe. A conversion counts only while `acq_en` is high.

The block has no level register. Software sizes its bulk reads from a free-running 16-bit down-counter instead. The counter steps down once for every counted conversion and wraps from 0x0000 to 0xFFFF. A value written to it is held pending and replaces the count only at the next conversion, which is the behaviour of a clocked timer. Software takes a one-cycle snapshot of the counter, so the two byte halves it reads always agree.

If a conversion arrives while the store is full and no read happens in that cycle, the sample is dropped and a sticky overrun flag is set. Every stored sample raises a data-ready interrupt flag. An overrun never raises that flag.

The store control is a three-state machine:
- FILL_EMPTY moves to FILL_PART on a push.
- FILL_PART moves to FILL_EMPTY when its level reaches zero, and to FILL_FULL when its level reaches the depth.
- FILL_FULL moves to FILL_PART on a pop with no push.

The counter control has two states:
- CNT_RUN moves to CNT_ARMED on a counter write.
- CNT_ARMED moves back to CNT_RUN when a conversion loads the pending value, unless the same cycle carries a new write.

Top module: `adc_sample_buffer`

## Requirements
- R1: After reset the store is empty and `rd_data`, `cnt_snap`, the counter, `ovr_flag` and `irq_data` are all zero.
- R2: A stored sample reads back as {result[11:0], tag[3:0]}, with the result in bits 15:4 and the tag in bits 3:0. Samples come out in arrival order, and `rd_data` is valid in the cycle after the `rd_req` cycle.
- R3: The store accepts exactly 1024 samples before it becomes full, and all 1024 are returned intact.
- R4: A conversion arriving while the store is full, with no read in the same cycle, is dropped. It sets `ovr_flag`, which stays set until `ovr_clr`.
- R5: Each stored sample sets `irq_data` until `irq_clr`. A dropped (overrun) conversion leaves `irq_data` unchanged.
- R6: A read of the empty store leaves `rd_data` at the last word returned and does not move the pointers, so the next sample stored still reads back correctly.
- R7: Each counted conversion decrements the counter by one, whether the sample is stored or dropped. The counter wraps from 0x0000 to 0xFFFF.
- R8: A value written with `cnt_wr` is not visible until the next counted conversion. That conversion loads the value instead of decrementing. A conversion in the same cycle as a write acts on the state before the write.
- R9: `cnt_latch` copies the counter into `cnt_snap` in one cycle. Otherwise `cnt_snap` holds.
- R10: While `acq_en` is low, conversions neither store nor count, and the samples already stored are kept.
- R11: A conversion and a read in the same cycle while the store is full both take effect. The oldest word is returned, the new sample is stored, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_en | input | 1 | Acquisition enable; gates conversions |
| conv_done | input | 1 | One-cycle strobe: a conversion has finished |
| conv_result | input | 12 | Conversion result |
| conv_tag | input | 4 | Tag placed in the low bits of the stored word |
| rd_req | input | 1 | Read one word from the store |
| rd_data | output | 16 | Data read port |
| cnt_wr | input | 1 | Write a pending load value to the counter |
| cnt_wdata | input | 16 | Counter load value |
| cnt_latch | input | 1 | Capture the counter into the snapshot |
| cnt_snap | output | 16 | Counter snapshot |
| ovr_clr | input | 1 | Clear the overrun flag |
| ovr_flag | output | 1 | Sticky overrun status |
| irq_clr | input | 1 | Clear the data-ready flag |
| irq_data | output | 1 | Data-ready interrupt flag |

## Verification
A push and a pop can fall in the same cycle. The interesting case is when the store is full, because that cycle decides whether the sample is kept or counted as an overrun. The bench fills the store to exactly 1024 words and checks that one further conversion raises the overrun flag. After clearing the flag, it drives a conversion together with a read. It then judges that the oldest word comes back, that the flag stays low, and that the full drain ends with the new sample in place. A counter write in the same cycle as a conversion is provoked as well, and it must decrement first and load only at the following conversion.

// File: rtl/abuf_pkg.sv
package abuf_pkg;
    localparam int RES_W  = 12;
    localparam int TAG_W  = 4;
    localparam int WORD_W = RES_W + TAG_W;
    localparam int CNT_W  = 16;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_state_e;

    typedef enum logic {
        CNT_RUN   = 1'b0,
        CNT_ARMED = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/abuf_store.sv
module abuf_store
    import abuf_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int W     = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_req,
    input  logic [W-1:0] wr_word,
    input  logic         pop_req,
    output logic [W-1:0] rd_word,
    output logic         full,
    output logic         dropped
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] level, level_nxt;
    fill_state_e   st, st_nxt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push   = push_req && ((st != FILL_FULL) || pop_req);
    assign do_pop    = pop_req && (st != FILL_EMPTY);
    assign dropped   = push_req && (st == FILL_FULL) && !pop_req;
    assign full      = (st == FILL_FULL);
    assign level_nxt = level + LW'(do_push) - LW'(do_pop);

    always_comb begin
        st_nxt = st;
        unique case (st)
            FILL_EMPTY: st_nxt = do_push ? FILL_PART : FILL_EMPTY;
            FILL_PART: begin
                if (level_nxt == '0)
                    st_nxt = FILL_EMPTY;
                else if (level_nxt == LW'(DEPTH))
                    st_nxt = FILL_FULL;
                else
                    st_nxt = FILL_PART;
            end
            FILL_FULL:  st_nxt = (do_pop && !do_push) ? FILL_PART : FILL_FULL;
            default:    st_nxt = FILL_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= FILL_EMPTY;
            level  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            st    <= st_nxt;
            level <= level_nxt;
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_word <= '0;
        else if (do_pop)
            rd_word <= mem[rd_ptr];
    end

    // R3
    full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FILL_FULL) |-> (level == LW'(DEPTH)));
    // R6
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && st == FILL_EMPTY) |=> $stable(rd_word));
    // R4
    drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> ($stable(level) && st == FILL_FULL));
    // R11
    swap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && st == FILL_FULL) |=> (st == FILL_FULL));
endmodule

// File: rtl/abuf_convcnt.sv
module abuf_convcnt
    import abuf_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          latch,
    output logic [CW-1:0] cnt_now,
    output logic [CW-1:0] snap
);
    cnt_state_e    st, st_nxt;
    logic [CW-1:0] load_q;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt_now;
        unique case (st)
            CNT_RUN: begin
                if (tick) cnt_nxt = cnt_now - 1'b1;
                if (wr)   st_nxt  = CNT_ARMED;
            end
            CNT_ARMED: begin
                if (tick) begin
                    cnt_nxt = load_q;
                    st_nxt  = wr ? CNT_ARMED : CNT_RUN;
                end
            end
            default: st_nxt = CNT_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= CNT_RUN;
            cnt_now <= '0;
            load_q  <= '0;
            snap    <= '0;
        end else begin
            st      <= st_nxt;
            cnt_now <= cnt_nxt;
            if (wr)    load_q <= wdata;
            if (latch) snap   <= cnt_now;
        end
    end

    // R7
    cnt_decr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st == CNT_RUN) |=> (cnt_now == CW'($past(cnt_now) - 1'b1)));
    // R8
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st == CNT_ARMED) |=> (cnt_now == $past(load_q)));
    // R8
    cnt_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick) |=> $stable(cnt_now));
    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch) |=> $stable(snap));
endmodule

// File: rtl/abuf_flags.sv
module abuf_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic stored,
    input  logic dropped,
    input  logic ovr_clr,
    input  logic irq_clr,
    output logic ovr_flag,
    output logic irq_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_flag <= 1'b0;
            irq_data <= 1'b0;
        end else begin
            if (dropped)      ovr_flag <= 1'b1;
            else if (ovr_clr) ovr_flag <= 1'b0;
            if (stored)       irq_data <= 1'b1;
            else if (irq_clr) irq_data <= 1'b0;
        end
    end

    // R4
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);
endmodule

// File: rtl/adc_sample_buffer.sv
module adc_sample_buffer
    import abuf_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_en,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic [TAG_W-1:0]  conv_tag,
    input  logic              rd_req,
    output logic [WORD_W-1:0] rd_data,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              cnt_latch,
    output logic [CNT_W-1:0]  cnt_snap,
    input  logic              ovr_clr,
    output logic              ovr_flag,
    input  logic              irq_clr,
    output logic              irq_data
);
    logic             accept;
    logic             full;
    logic             dropped;
    logic [CNT_W-1:0] cnt_now;

    assign accept = acq_en && conv_done;

    abuf_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (accept),
        .wr_word  ({conv_result, conv_tag}),
        .pop_req  (rd_req),
        .rd_word  (rd_data),
        .full     (full),
        .dropped  (dropped)
    );

    abuf_convcnt #(.CW(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (accept),
        .wr      (cnt_wr),
        .wdata   (cnt_wdata),
        .latch   (cnt_latch),
        .cnt_now (cnt_now),
        .snap    (cnt_snap)
    );

    abuf_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .stored   (accept && !dropped),
        .dropped  (dropped),
        .ovr_clr  (ovr_clr),
        .irq_clr  (irq_clr),
        .ovr_flag (ovr_flag),
        .irq_data (irq_data)
    );

    // R5
    ovr_noirq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && full && !rd_req && !irq_clr) |=> $stable(irq_data));
    // R10
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_en) |=> $stable(cnt_now));
    // R10
    idle_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_en && !ovr_clr) |=> $stable(ovr_flag));
endmodule

// File: tb/adc_sample_buffer_bench.sv
module adc_sample_buffer_bench;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n, acq_en, conv_done, rd_req, cnt_wr, cnt_latch, ovr_clr, irq_clr;
    logic [11:0] conv_result;
    logic [3:0]  conv_tag;
    logic [15:0] rd_data, cnt_wdata, cnt_snap;
    logic        ovr_flag, irq_data;

    int          n_total = 0;
    int          n_fail  = 0;
    logic [15:0] mq[$];
    logic [15:0] last_word = 16'h0;
    logic [15:0] exp_cnt   = 16'h0;
    logic        pend      = 1'b0;
    logic [15:0] pend_v    = 16'h0;
    logic [15:0] v;

    always #10 clk = ~clk;

    adc_sample_buffer #(.DEPTH(DEPTH)) u_adc_sample_buffer (
        .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .conv_done(conv_done),
        .conv_result(conv_result), .conv_tag(conv_tag), .rd_req(rd_req),
        .rd_data(rd_data), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cnt_latch(cnt_latch), .cnt_snap(cnt_snap), .ovr_clr(ovr_clr),
        .ovr_flag(ovr_flag), .irq_clr(irq_clr), .irq_data(irq_data)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic conv(input logic [11:0] d, input logic [3:0] t, input logic with_rd,
                        input string req);
        logic [15:0] er;
        er = last_word;
        conv_done = 1'b1; conv_result = d; conv_tag = t; rd_req = with_rd;
        @(negedge clk);
        conv_done = 1'b0; rd_req = 1'b0;
        if (with_rd && mq.size() > 0) er = mq.pop_front();
        if (acq_en) begin
            if (mq.size() < DEPTH) mq.push_back({d, t});
            if (pend) begin exp_cnt = pend_v; pend = 1'b0; end
            else exp_cnt = exp_cnt - 16'd1;
        end
        if (with_rd) begin
            chk(req, rd_data, er);
            last_word = er;
        end
    endtask

    task automatic rd_one(input string req);
        logic [15:0] er;
        er = (mq.size() > 0) ? mq.pop_front() : last_word;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk(req, rd_data, er);
        last_word = er;
    endtask

    task automatic drain(input string req);
        while (mq.size() > 0) rd_one(req);
    endtask

    task automatic snap_chk(input string req);
        cnt_latch = 1'b1;
        @(negedge clk);
        cnt_latch = 1'b0;
        chk(req, cnt_snap, exp_cnt);
    endtask

    task automatic cnt_write(input logic [15:0] val);
        cnt_wr = 1'b1; cnt_wdata = val;
        @(negedge clk);
        cnt_wr = 1'b0;
        pend = 1'b1; pend_v = val;
    endtask

    task automatic pulse_irq_clr();
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic pulse_ovr_clr();
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        rst_n = 1'b0; acq_en = 1'b0; conv_done = 1'b0; rd_req = 1'b0; cnt_wr = 1'b0;
        cnt_latch = 1'b0; ovr_clr = 1'b0; irq_clr = 1'b0;
        conv_result = '0; conv_tag = '0; cnt_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ovr", {15'b0, ovr_flag}, 16'h0);
        chk("R1 irq", {15'b0, irq_data}, 16'h0);
        chk("R1 data", rd_data, 16'h0);
        snap_chk("R1 counter");
        // R6 read of the empty store
        rd_one("R6 empty read");

        // R10 conversions ignored while acquisition is off
        for (int i = 0; i < 3; i++) conv(12'hABC, 4'h3, 1'b0, "R10");
        snap_chk("R10 no count");
        chk("R10 no irq", {15'b0, irq_data}, 16'h0);
        rd_one("R10 nothing stored");

        // R2 / R5 / R7 first sample
        acq_en = 1'b1;
        conv(12'h5A3, 4'h9, 1'b0, "R2");
        chk("R5 irq set", {15'b0, irq_data}, 16'h1);
        snap_chk("R7 wrap to FFFF");
        pulse_irq_clr();
        chk("R5 irq cleared", {15'b0, irq_data}, 16'h0);
        rd_one("R2 word layout");
        chk("R2 layout literal", rd_data, 16'h5A39);
        rd_one("R6 repeat last word");

        // R8 pending load
        cnt_write(16'h0005);
        snap_chk("R8 not yet loaded");
        conv(12'h001, 4'h1, 1'b0, "R8");
        snap_chk("R8 loaded");
        for (int i = 0; i < 6; i++) begin
            conv(12'(i * 3 + 2), 4'(i), 1'b0, "R7");
            snap_chk("R7 decrement/wrap");
        end
        // R8 write and conversion in the same cycle
        cnt_wr = 1'b1; cnt_wdata = 16'h0100;
        conv(12'h777, 4'h7, 1'b0, "R8");
        cnt_wr = 1'b0; pend = 1'b1; pend_v = 16'h0100;
        snap_chk("R8 same-cycle decrements");
        conv(12'h778, 4'h8, 1'b0, "R8");
        snap_chk("R8 loads after");
        // R9 snapshot holds without latch
        v = exp_cnt;
        conv(12'h779, 4'h9, 1'b0, "R9");
        @(negedge clk);
        chk("R9 snapshot holds", cnt_snap, v);
        snap_chk("R9 snapshot updates");
        drain("R2 order");

        // R3 fill sweep
        pulse_irq_clr();
        for (int i = 0; i < DEPTH; i++) conv(12'(i * 37 + 5), 4'(i), 1'b0, "R3");
        chk("R3 no overrun at capacity", {15'b0, ovr_flag}, 16'h0);
        pulse_irq_clr();
        conv(12'hFFF, 4'hF, 1'b0, "R4");
        chk("R4 overrun set", {15'b0, ovr_flag}, 16'h1);
        chk("R5 overrun leaves irq", {15'b0, irq_data}, 16'h0);
        @(negedge clk);
        chk("R4 overrun sticky", {15'b0, ovr_flag}, 16'h1);
        snap_chk("R7 dropped conversion counts");
        pulse_ovr_clr();
        chk("R4 overrun cleared", {15'b0, ovr_flag}, 16'h0);
        // R11 push and pop together when full
        conv(12'h3C3, 4'h5, 1'b1, "R11 oldest returned");
        chk("R11 no overrun", {15'b0, ovr_flag}, 16'h0);
        chk("R11 irq set", {15'b0, irq_data}, 16'h1);
        drain("R3 capacity contents");
        chk("R11 new sample last", last_word, 16'h3C35);
        rd_one("R6 empty after drain");

        // R10 retention across disable
        conv(12'h111, 4'h1, 1'b0, "R10");
        conv(12'h222, 4'h2, 1'b0, "R10");
        acq_en = 1'b0;
        conv(12'h333, 4'h3, 1'b0, "R10");
        conv(12'h444, 4'h4, 1'b0, "R10");
        snap_chk("R10 no count while off");
        acq_en = 1'b1;
        drain("R10 retained");
        rd_one("R6 hold after retained");
        conv(12'h555, 4'h5, 1'b0, "R6");
        rd_one("R6 pointers intact");

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule